// File: doc/BRIEF.md
# Multiplexer-Routed Accumulator Datapath

This block is the register and memory half of a small accumulator processor. It has four registers: an accumulator, a program counter, an address register and a data register. There is no shared bus. Each register has its own source multiplexer, and each multiplexer can select only from a fixed set of origins. An external sequencer drives three 3-bit operation fields every clock. The block decodes each field into at most one transfer. All transfers chosen in a cycle commit together on the next rising edge, and every one of them reads the values the registers held before that edge.

All memory traffic goes through the data register. A 2048-word by 16-bit memory is addressed by the address register. Its write data is always the data register, and its read data can go only into the data register. The arithmetic unit takes the accumulator and the data register as operands and always writes its result back into the accumulator. The operation fields are plain control pins and are sampled every cycle. No valid/ready handshake exists because the block neither accepts nor produces a stream. An all-zero field group is the idle pattern.

Top module: `acc_mux_datapath`

## Requirements
- R1: While rst_n is low, all four registers are cleared to zero. They read zero on the first sample after release.
- R2: When f1_op, f2_op and f3_op are all 000, no register and no memory word changes.
- R3: f1_op 001 loads the accumulator with (accumulator + data register) mod 2^16. f1_op 100 copies the data register into the accumulator.
- R4: f1_op 101 loads the address register with data register bits 10..0. f1_op 110 copies the program counter into the address register.
- R5: f2_op 100 loads the data register with memory word M[address register]. f2_op 101 copies the accumulator into it. f2_op 110 loads the program counter, zero-extended to 16 bits, into it.
- R6: f3_op 101 increments the program counter modulo 2^11. f3_op 110 copies the address register into it.
- R7: f1_op 111 stores the data register into M[address register]. A later f2_op 100 read at that address returns the stored value.
- R8: Every transfer in a cycle uses pre-edge values. Examples: f1_op 100 with f2_op 101 swaps the accumulator and the data register. f1_op 110 with f3_op 110 swaps the address register and the program counter.
- R9: Codes not listed above leave every register unchanged. These are f1_op 010 and 011, f2_op 001, 010, 011 and 111, and f3_op 001, 010, 011, 100 and 111.
- R10: If a write (f1_op 111) and a read (f2_op 100) fall in the same cycle, the data register receives the memory word as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| f1_op | input | 3 | First operation field (accumulator, address register, memory write) |
| f2_op | input | 3 | Second operation field (data register) |
| f3_op | input | 3 | Third operation field (program counter) |
| ac_q | output | 16 | Accumulator contents |
| dr_q | output | 16 | Data register contents |
| ar_q | output | 11 | Address register contents |
| pc_q | output | 11 | Program counter contents |

## Verification
Each register transfer is due on the first rising edge after its fields are presented. The bench drives the fields at a falling edge and compares all four registers at the following falling edge, with exactly one edge in between. A memory write shows up only one or more cycles later, through a read that lands in the data register. The bench therefore checks R7 and R10 on the cycle that performs that read. In every cycle, the expected values come from a bench model that applies the field encodings to the previous cycle's values.

// File: rtl/dp_pkg.sv
package dp_pkg;

  typedef enum logic [1:0] {AC_KEEP, AC_SUM, AC_FROM_DR} ac_src_e;
  typedef enum logic [1:0] {AR_KEEP, AR_FROM_DR, AR_FROM_PC} ar_src_e;
  typedef enum logic [1:0] {DR_KEEP, DR_FROM_MEM, DR_FROM_AC, DR_FROM_PC} dr_src_e;
  typedef enum logic [1:0] {PC_KEEP, PC_STEP, PC_FROM_AR} pc_src_e;

  typedef struct packed {
    ac_src_e ac_src;
    ar_src_e ar_src;
    dr_src_e dr_src;
    pc_src_e pc_src;
    logic    mem_we;
  } dp_sel_t;

  localparam logic [2:0] OP_NONE     = 3'b000;
  localparam logic [2:0] OP1_ADD     = 3'b001;
  localparam logic [2:0] OP1_DR2AC   = 3'b100;
  localparam logic [2:0] OP1_DR2AR   = 3'b101;
  localparam logic [2:0] OP1_PC2AR   = 3'b110;
  localparam logic [2:0] OP1_WRITE   = 3'b111;
  localparam logic [2:0] OP2_READ    = 3'b100;
  localparam logic [2:0] OP2_AC2DR   = 3'b101;
  localparam logic [2:0] OP2_PC2DR   = 3'b110;
  localparam logic [2:0] OP3_INCPC   = 3'b101;
  localparam logic [2:0] OP3_AR2PC   = 3'b110;

endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_pkg::*;
(
  input  logic [2:0] f1_op,
  input  logic [2:0] f2_op,
  input  logic [2:0] f3_op,
  output dp_sel_t    sel
);

  always_comb begin
    sel = '{ac_src: AC_KEEP, ar_src: AR_KEEP, dr_src: DR_KEEP,
            pc_src: PC_KEEP, mem_we: 1'b0};
    case (f1_op)
      OP1_ADD:   sel.ac_src = AC_SUM;
      OP1_DR2AC: sel.ac_src = AC_FROM_DR;
      OP1_DR2AR: sel.ar_src = AR_FROM_DR;
      OP1_PC2AR: sel.ar_src = AR_FROM_PC;
      OP1_WRITE: sel.mem_we = 1'b1;
      default:   ;
    endcase
    case (f2_op)
      OP2_READ:  sel.dr_src = DR_FROM_MEM;
      OP2_AC2DR: sel.dr_src = DR_FROM_AC;
      OP2_PC2DR: sel.dr_src = DR_FROM_PC;
      default:   ;
    endcase
    case (f3_op)
      OP3_INCPC: sel.pc_src = PC_STEP;
      OP3_AR2PC: sel.pc_src = PC_FROM_AR;
      default:   ;
    endcase
  end

endmodule

// File: rtl/dp_alu.sv
module dp_alu #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc,
  input  logic [DATA_W-1:0] opnd,
  input  logic              add_en,
  output logic [DATA_W-1:0] result
);

  always_comb begin
    if (add_en) result = acc + opnd;
    else        result = opnd;
  end

endmodule

// File: rtl/dp_mem.sv
module dp_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  assign rdata = store[addr];

endmodule

// File: rtl/dp_regs.sv
module dp_regs
  import dp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dp_sel_t           sel,
  input  logic [DATA_W-1:0] alu_res,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] ac,
  output logic [DATA_W-1:0] dr,
  output logic [ADDR_W-1:0] ar,
  output logic [ADDR_W-1:0] pc
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W-1:0] ac_d, dr_d;
  logic [ADDR_W-1:0] ar_d, pc_d;

  always_comb begin
    case (sel.ac_src)
      AC_SUM, AC_FROM_DR: ac_d = alu_res;
      default:            ac_d = ac;
    endcase
    case (sel.ar_src)
      AR_FROM_DR: ar_d = dr[ADDR_W-1:0];
      AR_FROM_PC: ar_d = pc;
      default:    ar_d = ar;
    endcase
    case (sel.dr_src)
      DR_FROM_MEM: dr_d = mem_rdata;
      DR_FROM_AC:  dr_d = ac;
      DR_FROM_PC:  dr_d = {{PAD_W{1'b0}}, pc};
      default:     dr_d = dr;
    endcase
    case (sel.pc_src)
      PC_STEP:    pc_d = pc + ADDR_W'(1);
      PC_FROM_AR: pc_d = ar;
      default:    pc_d = pc;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ac <= '0;
      dr <= '0;
      ar <= '0;
      pc <= '0;
    end else begin
      ac <= ac_d;
      dr <= dr_d;
      ar <= ar_d;
      pc <= pc_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == '{ac_src: AC_KEEP, ar_src: AR_KEEP, dr_src: DR_KEEP, pc_src: PC_KEEP, mem_we: 1'b0})
    |=> ($stable(ac) && $stable(dr) && $stable(ar) && $stable(pc))); // R2

  AST_AC_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.ac_src == AC_SUM) |=> (ac == ($past(ac) + $past(dr)))); // R3

  AST_AR_FROM_PC: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.ar_src == AR_FROM_PC) |=> (ar == $past(pc))); // R4

  AST_DR_FROM_AC: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.dr_src == DR_FROM_AC) |=> (dr == $past(ac))); // R5

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.pc_src == PC_STEP) |=> (pc == $past(pc) + ADDR_W'(1))); // R6

  AST_SWAP_AC_DR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel.ac_src == AC_FROM_DR && sel.dr_src == DR_FROM_AC)
    |=> (ac == $past(dr) && dr == $past(ac))); // R8

endmodule

// File: rtl/acc_mux_datapath.sv
module acc_mux_datapath
  import dp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        f1_op,
  input  logic [2:0]        f2_op,
  input  logic [2:0]        f3_op,
  output logic [DATA_W-1:0] ac_q,
  output logic [DATA_W-1:0] dr_q,
  output logic [ADDR_W-1:0] ar_q,
  output logic [ADDR_W-1:0] pc_q
);

  dp_sel_t           sel;
  logic [DATA_W-1:0] alu_res;
  logic [DATA_W-1:0] mem_rdata;

  dp_decode u_decode (
    .f1_op (f1_op),
    .f2_op (f2_op),
    .f3_op (f3_op),
    .sel   (sel)
  );

  dp_alu #(.DATA_W(DATA_W)) u_alu (
    .acc    (ac_q),
    .opnd   (dr_q),
    .add_en (sel.ac_src == AC_SUM),
    .result (alu_res)
  );

  dp_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (sel.mem_we && rst_n),
    .addr  (ar_q),
    .wdata (dr_q),
    .rdata (mem_rdata)
  );

  dp_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (sel),
    .alu_res   (alu_res),
    .mem_rdata (mem_rdata),
    .ac        (ac_q),
    .dr        (dr_q),
    .ar        (ar_q),
    .pc        (pc_q)
  );

endmodule

// File: tb/acc_mux_datapath_test.sv
module acc_mux_datapath_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  f1_op = 3'b000, f2_op = 3'b000, f3_op = 3'b000;
  logic [15:0] ac_q, dr_q;
  logic [10:0] ar_q, pc_q;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_ac, m_dr;
  logic [10:0] m_ar, m_pc;
  logic [15:0] m_mem [2048];

  always #2.5 clk = ~clk;

  acc_mux_datapath uut (
    .clk(clk), .rst_n(rst_n), .f1_op(f1_op), .f2_op(f2_op), .f3_op(f3_op),
    .ac_q(ac_q), .dr_q(dr_q), .ar_q(ar_q), .pc_q(pc_q)
  );

  task automatic chk(input string tag, input string nm, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag == "" ? "R3" : tag, "ac", ac_q, m_ac);
    chk(tag == "" ? "R4" : tag, "ar", {5'b0, ar_q}, {5'b0, m_ar});
    chk(tag == "" ? "R5" : tag, "dr", dr_q, m_dr);
    chk(tag == "" ? "R6" : tag, "pc", {5'b0, pc_q}, {5'b0, m_pc});
  endtask

  // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
  task automatic step(input logic [2:0] a, input logic [2:0] b, input logic [2:0] c, input string tag);
    logic [15:0] n_ac, n_dr;
    logic [10:0] n_ar, n_pc;
    f1_op = a; f2_op = b; f3_op = c;
    n_ac = m_ac; n_dr = m_dr; n_ar = m_ar; n_pc = m_pc;
    case (a)
      3'b001: n_ac = m_ac + m_dr;
      3'b100: n_ac = m_dr;
      3'b101: n_ar = m_dr[10:0];
      3'b110: n_ar = m_pc;
      default: ;
    endcase
    case (b)
      3'b100: n_dr = m_mem[m_ar];
      3'b101: n_dr = m_ac;
      3'b110: n_dr = {5'b0, m_pc};
      default: ;
    endcase
    case (c)
      3'b101: n_pc = m_pc + 11'd1;
      3'b110: n_pc = m_ar;
      default: ;
    endcase
    if (a == 3'b111) m_mem[m_ar] = m_dr;
    @(posedge clk);
    @(negedge clk);
    m_ac = n_ac; m_dr = n_dr; m_ar = n_ar; m_pc = n_pc;
    check_all(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    m_ac = '0; m_dr = '0; m_ar = '0; m_pc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_all("R1");

    // R2: idle group
    step(3'b000, 3'b000, 3'b000, "R2");

    // Fill memory: word a holds a (AR<-PC, DR<-PC, then write and PC+1). R7
    for (int a = 0; a < 2048; a++) begin
      step(3'b110, 3'b110, 3'b000, "R5");
      step(3'b111, 3'b000, 3'b101, "R7");
    end

    // R7: write a value, then read it back at the same address
    step(3'b001, 3'b000, 3'b000, "R3");
    step(3'b001, 3'b000, 3'b000, "R3");
    step(3'b000, 3'b101, 3'b000, "R5");
    step(3'b111, 3'b000, 3'b000, "R7");
    step(3'b000, 3'b110, 3'b000, "R5");
    step(3'b000, 3'b100, 3'b000, "R7");

    // R10: write and read together deliver old word
    step(3'b000, 3'b101, 3'b000, "R5");
    step(3'b111, 3'b100, 3'b000, "R10");
    step(3'b000, 3'b100, 3'b000, "R10");

    // R8: swaps
    step(3'b000, 3'b110, 3'b101, "R5");
    step(3'b100, 3'b101, 3'b000, "R8");
    step(3'b100, 3'b101, 3'b000, "R8");
    step(3'b101, 3'b000, 3'b101, "R4");
    step(3'b110, 3'b000, 3'b110, "R8");

    // R9: unlisted codes
    step(3'b010, 3'b001, 3'b001, "R9");
    step(3'b011, 3'b010, 3'b010, "R9");
    step(3'b010, 3'b011, 3'b011, "R9");
    step(3'b011, 3'b111, 3'b100, "R9");
    step(3'b000, 3'b111, 3'b111, "R9");

    // PC wrap at 2^11, R6
    step(3'b101, 3'b000, 3'b000, "R4");
    for (int k = 0; k < 2049; k++) step(3'b000, 3'b000, 3'b101, "R6");

    // Sweep of all 512 field combinations, several orderings
    for (int pass = 0; pass < 4; pass++) begin
      for (int i = 0; i < 512; i++) begin
        int idx;
        idx = (i * 37 + pass * 101) % 512;
        step(idx[8:6], idx[5:3], idx[2:0], "");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule